// File: doc/BRIEF.md
# DMA Event Status and Interrupt Register

This block collects five kinds of event reported by a multi-channel DMA engine and holds each as a sticky flag in a 16-bit status word. The events are:

- a receive done-queue write attempted while that queue is full;
- a transmit done-queue write attempted while that queue is full;
- a transmit FIFO underflow on any channel;
- a transmit pending-queue read;
- a transmit done-queue write.

Software reads the word through a read strobe. The read returns the flags and clears them. A flag comes back only when its event happens again.

The transmit done-queue write flag can be coalesced. A 3-bit threshold chooses how many writes must be seen before the flag sets, from every write up to one in 128. This lets software take one interrupt for a batch of completions.

A 5-bit mask selects which flags raise the interrupt outputs. There are two active-low outputs. The host interrupt is driven whenever an enabled flag is set. The local interrupt behaves the same way, but only while the mode input says the local bus is in configuration mode.

Top module: `dma_stat_irq`

## Requirements
- R1: While reset is asserted and right after it, `rd_data` reads 0 and both `host_irq_n` and `local_irq_n` are 1.
- R2: The flags sit at these `rd_data` bits: bit 11 receive done-queue error, bit 12 transmit underflow, bit 13 pending-queue read, bit 14 done-queue write, bit 15 transmit done-queue error. Bits 10 to 0 always read 0.
- R3: A one-cycle pulse on `rx_dq_err` sets bit 11, and a pulse on `tx_dq_err` sets bit 15. The bit is set on the clock edge that samples the pulse.
- R4: A pulse on any one bit of `tx_udf` sets bit 12. Pulses on several channels in the same cycle also set it.
- R5: A pulse on `tx_pq_rd` sets bit 13.
- R6: Bit 14 sets on the Nth `tx_dq_wr` pulse, where N = 2^`thr_sel` (0→1, 1→2, … 7→128). The internal write count restarts from zero each time the flag is set. If the count already reached is at or above a newly lowered N, the next write sets the flag.
- R7: A cycle with `rd_stb`=1 returns the current flags on `rd_data` and clears every flag at the end of that cycle. A cleared flag stays 0 until its event recurs.
- R8: An event arriving in the same cycle as `rd_stb` leaves its flag set after the read.
- R9: `host_irq_n` is 0 exactly when some flag is set whose mask bit is 1. Mask bit k (0 to 4) enables the flag at `rd_data` bit 11+k. The output follows the flags and the mask combinationally.
- R10: `local_irq_n` equals `host_irq_n` while `cfg_mode`=1, and is 1 while `cfg_mode`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_dq_err | input | 1 | Receive done-queue write attempted while full (pulse) |
| tx_udf | input | N_CH | Per-channel transmit FIFO underflow pulses |
| tx_pq_rd | input | 1 | Transmit pending-queue read (pulse) |
| tx_dq_wr | input | 1 | Transmit done-queue write (pulse) |
| tx_dq_err | input | 1 | Transmit done-queue write attempted while full (pulse) |
| rd_stb | input | 1 | Status read strobe; clears flags |
| irq_mask | input | 5 | Interrupt enable per flag, bit k for status bit 11+k |
| thr_sel | input | 3 | Coalescing threshold select, count = 2^thr_sel |
| cfg_mode | input | 1 | Local bus in configuration mode |
| rd_data | output | 16 | Status word |
| host_irq_n | output | 1 | Active-low host interrupt |
| local_irq_n | output | 1 | Active-low local interrupt |

## Verification
Two functions can fall in the same cycle: a read that clears the flags and a new event that sets one. The coalescing counter's terminal write can also coincide with a read. The bench provokes both collisions on purpose, first as directed cases and then in a long stretch of random pulses with frequent reads. A behavioural model in the bench judges every cycle: it gives the event priority over the clear and counts writes with a plain integer. The model's word and interrupt levels are compared with the outputs at every falling edge.

// File: rtl/dma_stat_pkg.sv
package dma_stat_pkg;
  localparam int REG_W   = 16;
  localparam int N_FLAG  = 5;
  localparam int FLAG_LO = 11;
  localparam int THR_W   = 3;
  localparam int CNT_W   = (1 << THR_W) - 1;

  localparam int F_RXERR = 0;
  localparam int F_UDF   = 1;
  localparam int F_PQRD  = 2;
  localparam int F_DQWR  = 3;
  localparam int F_TXERR = 4;

  function automatic logic [CNT_W:0] thr_count(input logic [THR_W-1:0] sel);
    logic [CNT_W:0] one;
    one = {{CNT_W{1'b0}}, 1'b1};
    return one << sel;
  endfunction

  function automatic logic [REG_W-1:0] pack_status(input logic [N_FLAG-1:0] f);
    logic [REG_W-1:0] w;
    w = '0;
    w[FLAG_LO +: N_FLAG] = f;
    return w;
  endfunction
endpackage

// File: rtl/dsi_flag.sv
module dsi_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= set_i | (q & ~clr_i);
  end

  a_r3_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q);
  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q);
  a_r7_holds_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !set_i) |=> $stable(q));
endmodule

// File: rtl/dsi_coalesce.sv
module dsi_coalesce
  import dma_stat_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [THR_W-1:0] thr_sel,
  output logic             fire_o
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   limit;
  logic [CNT_W:0]   next_cnt;

  assign limit    = thr_count(thr_sel);
  assign next_cnt = {1'b0, cnt} + 1'b1;
  assign fire_o   = wr_i && (next_cnt >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (fire_o) cnt <= '0;
    else if (wr_i)   cnt <= next_cnt[CNT_W-1:0];
  end

  a_r6_restart: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |=> (cnt == '0));
  a_r6_count_up: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !fire_o) |=> (cnt == $past(cnt) + 1'b1));
  a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(cnt));
  a_r6_single_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && thr_sel == '0) |-> fire_o);
endmodule

// File: rtl/dsi_irq.sv
module dsi_irq
  import dma_stat_pkg::*;
(
  input  logic [N_FLAG-1:0] flags,
  input  logic [N_FLAG-1:0] mask,
  input  logic              cfg_mode,
  output logic              host_irq_n,
  output logic              local_irq_n
);
  logic any_req;

  assign any_req     = |(flags & mask);
  assign host_irq_n  = ~any_req;
  assign local_irq_n = ~(any_req & cfg_mode);

  always_comb begin
    a_r10_local_gated: assert (cfg_mode || local_irq_n);
    a_r10_local_implies_host: assert (local_irq_n || !host_irq_n);
    a_r9_no_mask_no_irq: assert ((mask != '0) || host_irq_n);
  end
endmodule

// File: rtl/dma_stat_irq.sv
module dma_stat_irq
  import dma_stat_pkg::*;
#(
  parameter int N_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_dq_err,
  input  logic [N_CH-1:0]   tx_udf,
  input  logic              tx_pq_rd,
  input  logic              tx_dq_wr,
  input  logic              tx_dq_err,
  input  logic              rd_stb,
  input  logic [N_FLAG-1:0] irq_mask,
  input  logic [THR_W-1:0]  thr_sel,
  input  logic              cfg_mode,
  output logic [REG_W-1:0]  rd_data,
  output logic              host_irq_n,
  output logic              local_irq_n
);
  logic              ev_udf_any;
  logic              ev_dq_fire;
  logic [N_FLAG-1:0] ev_set;
  logic [N_FLAG-1:0] flags;

  assign ev_udf_any = |tx_udf;

  dsi_coalesce u_coal (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (tx_dq_wr),
    .thr_sel (thr_sel),
    .fire_o  (ev_dq_fire)
  );

  always_comb begin
    ev_set          = '0;
    ev_set[F_RXERR] = rx_dq_err;
    ev_set[F_UDF]   = ev_udf_any;
    ev_set[F_PQRD]  = tx_pq_rd;
    ev_set[F_DQWR]  = ev_dq_fire;
    ev_set[F_TXERR] = tx_dq_err;
  end

  for (genvar k = 0; k < N_FLAG; k++) begin : g_flag
    dsi_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (ev_set[k]),
      .clr_i (rd_stb),
      .q     (flags[k])
    );
  end

  assign rd_data = pack_status(flags);

  dsi_irq u_irq (
    .flags       (flags),
    .mask        (irq_mask),
    .cfg_mode    (cfg_mode),
    .host_irq_n  (host_irq_n),
    .local_irq_n (local_irq_n)
  );

  a_r2_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[FLAG_LO-1:0] == '0);
  a_r4_any_channel: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_udf != '0) |=> rd_data[FLAG_LO+F_UDF]);
  a_r8_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && tx_pq_rd) |=> rd_data[FLAG_LO+F_PQRD]);
  a_r5_pq_sets: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pq_rd |=> rd_data[FLAG_LO+F_PQRD]);
endmodule

// File: tb/dma_stat_irq_tb.sv
module dma_stat_irq_tb;
  localparam int NCH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_dq_err = 0, tx_pq_rd = 0, tx_dq_wr = 0, tx_dq_err = 0, rd_stb = 0;
  logic [NCH-1:0] tx_udf = '0;
  logic [4:0] irq_mask = '0;
  logic [2:0] thr_sel = '0;
  logic cfg_mode = 0;
  logic [15:0] rd_data;
  logic host_irq_n, local_irq_n;

  int errors = 0, checks = 0;
  string tag = "R1";
  bit [4:0] m_flag = '0;
  int m_cnt = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dma_stat_irq #(.N_CH(NCH)) u_dut (
    .clk(clk), .rst_n(rst_n), .rx_dq_err(rx_dq_err), .tx_udf(tx_udf),
    .tx_pq_rd(tx_pq_rd), .tx_dq_wr(tx_dq_wr), .tx_dq_err(tx_dq_err),
    .rd_stb(rd_stb), .irq_mask(irq_mask), .thr_sel(thr_sel), .cfg_mode(cfg_mode),
    .rd_data(rd_data), .host_irq_n(host_irq_n), .local_irq_n(local_irq_n)
  );

  task automatic check(string t, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", t, act, exp, $time);
    end
  endtask

  function automatic int needed(int sel);
    int n = 1;
    for (int i = 0; i < sel; i++) n = n * 2;
    return n;
  endfunction

  task automatic compare_all();
    bit req;
    logic [15:0] exp_word;
    exp_word = 16'd0;
    for (int i = 0; i < 5; i++) exp_word[11+i] = m_flag[i];
    req = |(m_flag & irq_mask);
    check(tag, rd_data, exp_word);
    check("R2", {5'd0, rd_data[10:0]}, 16'd0);
    check("R9", {15'd0, host_irq_n}, {15'd0, !req});
    check("R10", {15'd0, local_irq_n}, {15'd0, !(req && cfg_mode)});
  endtask

  task automatic step();
    bit [4:0] ev;
    @(posedge clk);
    ev = '0;
    ev[0] = rx_dq_err;
    ev[1] = (tx_udf != 0);
    ev[2] = tx_pq_rd;
    ev[4] = tx_dq_err;
    if (tx_dq_wr) begin
      if (m_cnt + 1 >= needed(int'(thr_sel))) begin ev[3] = 1; m_cnt = 0; end
      else m_cnt++;
    end
    m_flag = rd_stb ? ev : (m_flag | ev);
    @(negedge clk);
    compare_all();
    rx_dq_err = 0; tx_udf = '0; tx_pq_rd = 0; tx_dq_wr = 0; tx_dq_err = 0; rd_stb = 0;
  endtask

  task automatic do_read();
    rd_stb = 1; step();
  endtask

  initial begin
    int guard = 0;
    while (!done && guard < 150000) begin @(posedge clk); guard++; end
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    irq_mask = 5'h1f; cfg_mode = 1;
    repeat (2) @(negedge clk);
    tag = "R1";
    check("R1", rd_data, 16'd0);
    check("R1", {14'd0, host_irq_n, local_irq_n}, 16'd3);
    rst_n = 1;
    @(negedge clk);
    compare_all();

    tag = "R3";
    rx_dq_err = 1; step();
    tx_dq_err = 1; step();
    do_read(); step();

    tag = "R4";
    for (int c = 0; c < NCH; c++) begin
      tx_udf[c] = 1; step(); do_read();
    end
    tx_udf = '1; step(); do_read();

    tag = "R5";
    tx_pq_rd = 1; step(); do_read();

    tag = "R6";
    thr_sel = 0;
    tx_dq_wr = 1; step(); do_read();
    thr_sel = 2;
    for (int i = 0; i < 4; i++) begin tx_dq_wr = 1; step(); end
    do_read();
    thr_sel = 7;
    for (int i = 0; i < 127; i++) begin tx_dq_wr = 1; step(); end
    check("R6", rd_data, 16'd0);
    tx_dq_wr = 1; step();
    check("R6", rd_data, 16'h4000);
    do_read();
    thr_sel = 3;
    for (int i = 0; i < 6; i++) begin tx_dq_wr = 1; step(); end
    thr_sel = 1;
    tx_dq_wr = 1; step();
    check("R6", rd_data, 16'h4000);
    do_read();

    tag = "R7";
    rx_dq_err = 1; tx_pq_rd = 1; step();
    do_read();
    repeat (3) step();
    check("R7", rd_data, 16'd0);

    tag = "R8";
    tx_dq_err = 1; step();
    rd_stb = 1; tx_dq_err = 1; step();
    check("R8", rd_data, 16'h8000);
    thr_sel = 0;
    rd_stb = 1; tx_dq_wr = 1; step();
    do_read();

    tag = "R9";
    for (int k = 0; k < 5; k++) begin
      irq_mask = 5'h1f ^ (5'd1 << k);
      case (k)
        0: rx_dq_err = 1;
        1: tx_udf[0] = 1;
        2: tx_pq_rd = 1;
        3: tx_dq_wr = 1;
        default: tx_dq_err = 1;
      endcase
      step();
      check("R9", {15'd0, host_irq_n}, 16'd1);
      irq_mask = 5'd1 << k; #1;
      check("R9", {15'd0, host_irq_n}, 16'd0);
      do_read();
    end

    tag = "R10";
    irq_mask = 5'h1f;
    tx_pq_rd = 1; step();
    cfg_mode = 0; #1;
    check("R10", {14'd0, host_irq_n, local_irq_n}, 16'd1);
    cfg_mode = 1; #1;
    check("R10", {14'd0, host_irq_n, local_irq_n}, 16'd0);
    do_read();

    tag = "R8";
    for (int i = 0; i < 3000; i++) begin
      rx_dq_err = ($urandom_range(0, 15) == 0);
      tx_udf    = ($urandom_range(0, 7) == 0) ? NCH'($urandom) : '0;
      tx_pq_rd  = ($urandom_range(0, 7) == 0);
      tx_dq_wr  = ($urandom_range(0, 1) == 0);
      tx_dq_err = ($urandom_range(0, 15) == 0);
      rd_stb    = ($urandom_range(0, 3) == 0);
      if ($urandom_range(0, 63) == 0) thr_sel = 3'($urandom);
      if ($urandom_range(0, 31) == 0) irq_mask = 5'($urandom);
      if ($urandom_range(0, 31) == 0) cfg_mode = ~cfg_mode;
      step();
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule